// File: doc/BRIEF.md
# MII Management Frame Master

This block drives the two-wire PHY management interface from a system clock. It takes one request at a time: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It divides the system clock down to the management clock and shifts the whole frame out. Each frame has a run of ones to synchronise the PHY, then the start pattern, the opcode, both addresses, the turnaround, 16 data bits, and a final clock period in which the line is left undriven.

The data line is split into an output value, an output enable and an input, which the pad ring combines into one pulled-up bidirectional wire. On a read, the master releases the line at the first turnaround bit. It expects the PHY to pull the line low on the second turnaround bit, and then samples the 16 data bits on rising clock edges. When the PHY does not pull the line low, the master still finishes the frame, returns 0xFFFF and raises a no-response flag. `busy_o` stays high from the cycle after acceptance until the closing quiescent period ends, and `done_o` pulses for one cycle at that point.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mdc_o`, `mdio_oe_o` and `no_resp_o` are 0.
- R2: Each management clock phase (high or low) lasts HALF_DIV system clock cycles while a frame runs. `mdc_o` stays low while idle. A frame keeps `busy_o` high for exactly 130*HALF_DIV cycles (65 clock periods).
- R3: Every frame begins with PRE_LEN (default 32) clock periods in which the master drives the line to 1.
- R4: A write frame drives, MSB first: start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 write data bits.
- R5: A read frame drives start 01, opcode 10 and both addresses. The master then keeps its output enable low from the first turnaround bit through the end of the frame.
- R6: The master changes `mdio_o` or `mdio_oe_o` during a frame only at the system clock edge where `mdc_o` falls, so both are stable around every rising edge.
- R7: On a read where the line is 0 at the rising edge of the second turnaround bit, the 16 bits sampled on the following rising edges are returned MSB first in `rdata_o`, with `no_resp_o` = 0.
- R8: On a read where the second turnaround bit is sampled as 1, `rdata_o` = 0xFFFF and `no_resp_o` = 1.
- R9: The 65th clock period of every frame leaves the line undriven. `done_o` pulses for one cycle at the falling edge that closes it, and `busy_o` drops in the same cycle. After a write, `rdata_o` = 0 and `no_resp_o` = 0.
- R10: A request presented while `busy_o` is high is ignored: the running frame is unchanged and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_read_i | input | 1 | 1 = read frame, 0 = write frame |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| rdata_o | output | 16 | Read result |
| no_resp_o | output | 1 | Read turnaround was not pulled low |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench records the line and the master's enable at every rising management clock edge. It rebuilds each frame and compares it with a frame built by a bench function. A wrong opcode, a swapped address order or an LSB-first shift would show up as a header mismatch. Reads are run against a responder that answers with data 0xFFFF, with 0x0000, and not at all. This separates a real all-ones answer from a missing PHY, and it catches a sample taken one edge early or late, which shifts the data by one bit. The bench also measures the clock phases, the busy length and where the outputs change, and it flags bus contention. A design that drives the quiescent period, ends a period early or moves data on a rising edge fails these checks. A request sent in the middle of a frame must leave that frame and the following idle time untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 2 + 2 + 2 * ADDR_W;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term   = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = run_i & term & ~mdc_q;
  assign fall_o = run_i & term & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  localparam int FRAME_BITS = PRE_LEN + HDR_BITS + 2 + DATA_W,
  localparam int IDX_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mgmt_req_t        req_i,
  input  logic             fall_i,
  output logic             accept_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             is_read_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  localparam int TA1_IDX = PRE_LEN + HDR_BITS;

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      bit_idx_q;
  logic                  busy_q, done_q, rd_q;
  logic [FRAME_BITS-1:0] frame_d;
  logic                  last_bit;

  assign frame_d = {{PRE_LEN{1'b1}}, START_PAT,
                    req_i.rd ? OPC_READ : OPC_WRITE,
                    req_i.phy, req_i.regad,
                    req_i.rd ? 2'b11 : TA_WRITE,
                    req_i.rd ? {DATA_W{1'b1}} : req_i.wdata};

  assign accept_o = start_i & ~busy_q;
  assign last_bit = (bit_idx_q == IDX_W'(FRAME_BITS));
  assign finish_o = busy_q & fall_i & last_bit;

  // master drives all bits of a write; a read releases the line from turnaround on
  assign mdio_oe_o = busy_q && !last_bit && (!rd_q || bit_idx_q < IDX_W'(TA1_IDX));
  assign mdio_o    = mdio_oe_o & sh_q[FRAME_BITS-1];

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign is_read_o = rd_q;
  assign bit_idx_o = bit_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      bit_idx_q <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        sh_q      <= frame_d;
        bit_idx_q <= '0;
        busy_q    <= 1'b1;
        rd_q      <= req_i.rd;
      end else if (busy_q && fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_idx_q <= bit_idx_q + 1'b1;
          sh_q      <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R6
  mdio_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) &&
     (mdio_o != $past(mdio_o) || mdio_oe_o != $past(mdio_oe_o))) |-> $past(fall_i));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R10
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> ($stable(bit_idx_q) && $stable(rd_q)));
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  localparam int FRAME_BITS = PRE_LEN + HDR_BITS + 2 + DATA_W,
  localparam int IDX_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              rise_i,
  input  logic              finish_i,
  input  logic              is_read_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              no_resp_o
);
  localparam int TA2_IDX  = PRE_LEN + HDR_BITS + 1;
  localparam int DEND_IDX = TA2_IDX + DATA_W;

  logic              ta_ok_q;
  logic [DATA_W-1:0] sh_q;
  logic              in_data;

  assign in_data = (bit_idx_i > IDX_W'(TA2_IDX)) && (bit_idx_i <= IDX_W'(DEND_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ta_ok_q   <= 1'b0;
      sh_q      <= '0;
      rdata_o   <= '0;
      no_resp_o <= 1'b0;
    end else begin
      if (accept_i) begin
        ta_ok_q <= 1'b0;
        sh_q    <= '0;
      end else if (rise_i && is_read_i) begin
        if (bit_idx_i == IDX_W'(TA2_IDX)) ta_ok_q <= ~mdio_i;
        if (in_data) sh_q <= {sh_q[DATA_W-2:0], mdio_i};
      end
      if (finish_i) begin
        if (is_read_i) begin
          rdata_o   <= ta_ok_q ? sh_q : {DATA_W{1'b1}};
          no_resp_o <= ~ta_ok_q;
        end else begin
          rdata_o   <= '0;
          no_resp_o <= 1'b0;
        end
      end
    end
  end

  // R8
  no_resp_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_resp_o) |-> (rdata_o == {DATA_W{1'b1}}));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_read_i,
  input  logic [4:0]  req_phy_i,
  input  logic [4:0]  req_reg_i,
  input  logic [15:0] req_wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        no_resp_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = PRE_LEN + HDR_BITS + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);

  mgmt_req_t        req;
  logic             rise, fall, accept, finish, is_read;
  logic [IDX_W-1:0] bit_idx;

  assign req = '{rd: req_read_i, phy: req_phy_i, regad: req_reg_i, wdata: req_wdata_i};

  mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy_o),
    .mdc_o (mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk_i    (clk_i),    .rst_ni   (rst_ni),
    .start_i  (req_valid_i), .req_i (req),
    .fall_i   (fall),     .accept_o (accept),
    .finish_o (finish),   .busy_o   (busy_o),
    .done_o   (done_o),   .is_read_o(is_read),
    .bit_idx_o(bit_idx),  .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  mdio_rx_capture #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk_i    (clk_i),   .rst_ni   (rst_ni),
    .accept_i (accept),  .rise_i   (rise),
    .finish_i (finish),  .is_read_i(is_read),
    .bit_idx_i(bit_idx), .mdio_i   (mdio_i),
    .rdata_o  (rdata_o), .no_resp_o(no_resp_o)
  );
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 2;
  localparam int NB   = 65;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_read = 0;
  logic [4:0] req_phy = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic busy_o, done_o, no_resp_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;
  logic phy_oe = 0, phy_d = 1;
  wire  mdio_line = mdio_oe_o ? mdio_o : (phy_oe ? phy_d : 1'b1);

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF), .PRE_LEN(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_read_i(req_read),
    .req_phy_i(req_phy), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .no_resp_o(no_resp_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_line));

  int n_chk = 0, n_bad = 0;
  logic cap_val [NB];
  logic cap_oe  [NB];
  int rise_cnt = 0;
  logic cur_rd = 0, cur_resp = 0;
  logic [15:0] cur_data = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural PHY: samples on rising MDC, drives after it
  always @(posedge mdc_o) begin
    int nx;
    if (rise_cnt < NB) begin
      cap_val[rise_cnt] = mdio_line;
      cap_oe[rise_cnt]  = mdio_oe_o;
    end
    rise_cnt++;
    nx = rise_cnt;
    #1;
    if (cur_rd && cur_resp && nx >= 47 && nx <= 63) begin
      phy_oe = 1;
      phy_d  = (nx == 47) ? 1'b0 : cur_data[63-nx];
    end else begin
      phy_oe = 0;
      phy_d  = 1;
    end
  end

  // line monitors
  int idle_err = 0, period_err = 0, edge_err = 0, cont_err = 0, busy_cnt = 0;
  int hi_run = 0, lo_run = 0;
  logic prev_mdc = 0, prev_busy = 0;
  logic [1:0] prev_out = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy_o && mdc_o) idle_err++;
      if (busy_o) busy_cnt++;
      if (mdio_oe_o && phy_oe) cont_err++;
      if (mdc_o) begin
        if (!prev_mdc) begin
          if (lo_run != HALF) period_err++;
          lo_run = 0;
        end
        hi_run++;
      end else begin
        if (prev_mdc) begin
          if (hi_run != HALF) period_err++;
          hi_run = 0;
        end
        if (busy_o) lo_run++;
      end
      if (prev_busy && busy_o && ({mdio_oe_o, mdio_o} != prev_out) && !(prev_mdc && !mdc_o))
        edge_err++;
      prev_mdc  = mdc_o;
      prev_busy = busy_o;
      prev_out  = {mdio_oe_o, mdio_o};
    end
  end

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic resp, input logic poke);
    logic [63:0] act_v, exp_v;
    logic [64:0] act_oe, exp_oe;
    int waited;
    @(negedge clk);
    rise_cnt = 0; idle_err = 0; period_err = 0; edge_err = 0; cont_err = 0; busy_cnt = 0;
    hi_run = 0; lo_run = 0;
    cur_rd = rd; cur_resp = resp; cur_data = d;
    req_read = rd; req_phy = p; req_reg = r; req_wdata = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (50) @(negedge clk);
      req_read = ~rd; req_phy = ~p; req_reg = ~r; req_wdata = ~d; req_valid = 1;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    waited = 0;
    while (!done_o && waited < 3000) begin @(negedge clk); waited++; end
    check(done_o, "R9 done pulse seen", {63'd0, done_o}, 64'd1);
    check(!busy_o, "R9 busy low with done", {63'd0, busy_o}, 64'd0);
    check(rise_cnt == NB, "R9 clock periods per frame", rise_cnt, NB);
    check(busy_cnt == 130*HALF, "R2 busy length", busy_cnt, 130*HALF);
    check(period_err == 0 && idle_err == 0, "R2 mdc phase length", period_err + idle_err, 0);
    check(edge_err == 0, "R6 output moves only on falling mdc", edge_err, 0);
    check(cont_err == 0, "R5 no line contention", cont_err, 0);
    for (int i = 0; i < 64; i++) act_v[63-i] = cap_val[i];
    for (int i = 0; i < NB; i++) act_oe[64-i] = cap_oe[i];
    exp_v  = exp_frame(rd, p, r, d);
    exp_oe = rd ? {{46{1'b1}}, 19'd0} : {{64{1'b1}}, 1'b0};
    check(act_v[63:32] == exp_v[63:32], "R3 preamble", act_v[63:32], exp_v[63:32]);
    check(act_v[31:18] == exp_v[31:18], rd ? "R5 read header" : "R4 write header",
          act_v[31:18], exp_v[31:18]);
    check(act_oe == exp_oe, rd ? "R5 read enable pattern" : "R9 quiescent enable pattern",
          act_oe[63:0], exp_oe[63:0]);
    if (!rd) begin
      check(act_v[17:0] == exp_v[17:0], "R4 turnaround and data", act_v[17:0], exp_v[17:0]);
      check(rdata_o == 0 && !no_resp_o, "R9 write result cleared", {rdata_o, no_resp_o}, 0);
    end else if (resp) begin
      check(rdata_o == d && !no_resp_o, "R7 read data", {rdata_o, no_resp_o}, {d, 1'b0});
    end else begin
      check(rdata_o == 16'hFFFF && no_resp_o, "R8 no response", {rdata_o, no_resp_o},
            {16'hFFFF, 1'b1});
    end
    if (poke) begin
      repeat (200) @(negedge clk);
      check(!busy_o && rise_cnt == NB, "R10 request while busy ignored", rise_cnt, NB);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mdc_o && !mdio_oe_o && !no_resp_o, "R1 reset state",
          {busy_o, done_o, mdc_o, mdio_oe_o, no_resp_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!mdc_o && !busy_o, "R1 idle after reset", {mdc_o, busy_o}, 0);

    run_frame(0, 5'h1F, 5'h00, 16'hA5A5, 0, 0);
    run_frame(1, 5'h00, 5'h1F, 16'hFFFF, 1, 0);
    run_frame(1, 5'h15, 5'h0A, 16'h0000, 1, 0);
    run_frame(1, 5'h03, 5'h01, 16'h1234, 0, 0);
    run_frame(1, 5'h0C, 5'h11, 16'h8001, 1, 1);
    run_frame(0, 5'h0A, 5'h15, 16'h0001, 0, 1);
    for (int k = 0; k < 30; k++) begin
      logic rd, rs;
      rd = 1'($urandom);
      rs = 1'($urandom);
      run_frame(rd, 5'($urandom), 5'($urandom), 16'($urandom), rs, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule